// File: doc/BRIEF.md
# Multi-Vector Message Interrupt Requester

This block gathers single-cycle event pulses from up to 32 user-logic sources. It turns each event into one interrupt request toward the configuration side of a PCIe endpoint. Host software can then identify the event from the vector number alone and does not need a status read. Each source has a sticky pending flag. One pending source is served at a time, and the lowest index goes first.

The vector sent for a source is folded to fit the number of vectors the host actually granted. The host writes this count as a 3-bit power-of-two code, and it may be smaller than the number requested. With a single granted vector, every source shares vector 0. The request is an active-low strobe that stays asserted, with the vector held stable, until the endpoint drives its active-low ready. When message interrupts are disabled, the same handshake carries a shared legacy interrupt instead, and the vector is forced to zero.

Top module: `msi_irq_req`

## Requirements
- R1: After reset `ep_req_n_o` is 1, `ep_vec_o` is 0 and `legacy_o` is 0.
- R2: A pulse sampled at clock edge k on an idle block drives `ep_req_n_o` low after edge k+1, and not before.
- R3: When several sources are pending, the lowest index is served first. The served index is latched when the request is raised and is not replaced by later arrivals until it is accepted.
- R4: In message mode (`msi_en_i` high when the request is raised) `legacy_o` is 0. `ep_vec_o` equals the source index AND (G-1), where G = 2^min(code,5) and `grant_code_i` is sampled when the request is raised. Codes 0..5 mean 1, 2, 4, 8, 16 and 32 vectors.
- R5: Grant codes 6 and 7 behave as 32 granted vectors, so the vector equals the source index.
- R6: While the request is low and `ep_rdy_n_i` is high, `ep_req_n_o`, `ep_vec_o` and `legacy_o` hold their values. `ep_rdy_n_i` has no effect while no request is outstanding.
- R7: An edge where `ep_req_n_o` and `ep_rdy_n_i` are both low accepts the request. `ep_req_n_o` is then high for at least one cycle, and the served source's pending flag is cleared only by that acceptance.
- R8: Extra pulses from a source that is already pending merge into one request.
- R9: A pulse from the served source in its acceptance cycle is kept and produces a further request.
- R10: If `msi_en_i` is low when a request is raised, the request uses legacy mode: `legacy_o` is 1 and `ep_vec_o` is 0.
- R11: If `msi_en_i` falls while a message request is outstanding, that request completes unchanged, and later requests use legacy mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_pulse_i | input | NUM_SRC | One-cycle event pulses, one per source |
| msi_en_i | input | 1 | Message interrupts enabled by host |
| grant_code_i | input | GRANT_W | Log2 of granted vector count |
| ep_rdy_n_i | input | 1 | Active-low accept from endpoint |
| ep_req_n_o | output | 1 | Active-low interrupt request |
| ep_vec_o | output | VEC_W | Vector number presented with the request |
| legacy_o | output | 1 | Current request is a shared legacy interrupt |

## Verification
The assertions check on every cycle the following: the request and vector stay stable until acceptance, the request is released after acceptance, a pending flag clears only on acceptance, a raised vector is inside the granted range, the lowest pending index is chosen, and legacy requests carry vector zero. Only the bench scenarios can show the exact raise latency after a pulse, the merging of repeated pulses, the retention of a pulse that lands in the acceptance cycle, and the switch to legacy mode after the enable drops mid-handshake.

// File: rtl/irq_req_pkg.sv
package irq_req_pkg;

   typedef enum logic [0:0] {
      HS_IDLE = 1'b0,
      HS_WAIT = 1'b1
   } hs_state_e;

   // Number of vector-index bits usable for a grant code, capped at max_log.
   function automatic int grant_log_f(input int code, input int max_log);
      return (code > max_log) ? max_log : code;
   endfunction

endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
   parameter int NUM_SRC = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] set_i,
   input  logic [NUM_SRC-1:0] clr_i,
   output logic [NUM_SRC-1:0] pend_o
);

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
      logic flag_q;

      // A new pulse wins over a clear in the same cycle: it is a fresh event.
      always_ff @(posedge clk) begin
         if (!rst_n) flag_q <= 1'b0;
         else        flag_q <= (flag_q & ~clr_i[g]) | set_i[g];
      end

      assign pend_o[g] = flag_q;

      assert_clear_on_accept_R7 : assert property (@(posedge clk) disable iff (!rst_n)
         $fell(pend_o[g]) |-> $past(clr_i[g]));

      assert_merge_keeps_R8 : assert property (@(posedge clk) disable iff (!rst_n)
         (pend_o[g] && !clr_i[g]) |=> pend_o[g]);
   end

endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
   parameter int NUM_SRC = 32,
   localparam int IW     = $clog2(NUM_SRC)
) (
   input  logic [NUM_SRC-1:0] req_i,
   output logic               any_o,
   output logic [IW-1:0]      idx_o
);

   always_comb begin
      any_o = 1'b0;
      idx_o = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (req_i[i]) begin
            any_o = 1'b1;
            idx_o = IW'(i);
         end
      end
   end

endmodule

// File: rtl/irq_vec_fold.sv
module irq_vec_fold #(
   parameter int NUM_SRC = 32,
   parameter int VEC_W   = 8,
   parameter int GRANT_W = 3,
   localparam int IW     = $clog2(NUM_SRC)
) (
   input  logic [IW-1:0]      idx_i,
   input  logic [GRANT_W-1:0] code_i,
   input  logic               msi_i,
   output logic [VEC_W-1:0]   vec_o
);

   logic [IW-1:0] mask;
   logic [IW-1:0] folded;

   // Bit b of the mask is kept once the granted count exceeds 2^b.
   for (genvar b = 0; b < IW; b++) begin : g_mask
      assign mask[b] = (int'(code_i) > b);
   end

   assign folded = msi_i ? (idx_i & mask) : '0;

   if (VEC_W == IW) begin : g_same
      assign vec_o = folded;
   end else begin : g_ext
      assign vec_o = {{(VEC_W - IW){1'b0}}, folded};
   end

endmodule

// File: rtl/irq_hs_ctrl.sv
module irq_hs_ctrl
   import irq_req_pkg::*;
#(
   parameter int NUM_SRC = 32,
   parameter int VEC_W   = 8,
   localparam int IW     = $clog2(NUM_SRC)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               any_i,
   input  logic [IW-1:0]      idx_i,
   input  logic [VEC_W-1:0]   vec_i,
   input  logic               msi_i,
   input  logic               rdy_n_i,
   output logic               req_n_o,
   output logic [VEC_W-1:0]   vec_o,
   output logic               leg_o,
   output logic [IW-1:0]      sel_o,
   output logic [NUM_SRC-1:0] clr_o
);

   hs_state_e state_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= HS_IDLE;
         req_n_o <= 1'b1;
         vec_o   <= '0;
         leg_o   <= 1'b0;
         sel_o   <= '0;
      end else begin
         unique case (state_q)
            HS_IDLE: begin
               if (any_i) begin
                  state_q <= HS_WAIT;
                  req_n_o <= 1'b0;
                  sel_o   <= idx_i;
                  vec_o   <= vec_i;
                  leg_o   <= ~msi_i;
               end
            end
            HS_WAIT: begin
               if (!rdy_n_i) begin
                  state_q <= HS_IDLE;
                  req_n_o <= 1'b1;
               end
            end
            default: state_q <= HS_IDLE;
         endcase
      end
   end

   always_comb begin
      clr_o = '0;
      if (state_q == HS_WAIT && !rdy_n_i) clr_o[sel_o] = 1'b1;
   end

   assert_hold_until_ready_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (!req_n_o && rdy_n_i) |=> (!req_n_o && $stable(vec_o) && $stable(leg_o)));

   assert_release_after_accept_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (!req_n_o && !rdy_n_i) |=> req_n_o);

   assert_legacy_vec_zero_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      (!req_n_o && leg_o) |-> (vec_o == '0));

endmodule

// File: rtl/msi_irq_req.sv
module msi_irq_req
   import irq_req_pkg::*;
#(
   parameter int NUM_SRC = 32,
   parameter int VEC_W   = 8,
   parameter int GRANT_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_pulse_i,
   input  logic               msi_en_i,
   input  logic [GRANT_W-1:0] grant_code_i,
   input  logic               ep_rdy_n_i,
   output logic               ep_req_n_o,
   output logic [VEC_W-1:0]   ep_vec_o,
   output logic               legacy_o
);

   localparam int IW = $clog2(NUM_SRC);

   if (NUM_SRC < 2 || NUM_SRC > 32) begin : g_bad_src
      $error("msi_irq_req: NUM_SRC must lie in 2..32");
   end
   if (VEC_W < IW) begin : g_bad_vec
      $error("msi_irq_req: VEC_W too narrow for source index");
   end
   if (GRANT_W < 3) begin : g_bad_grant
      $error("msi_irq_req: GRANT_W must be at least 3");
   end

   logic [NUM_SRC-1:0] pend_w;
   logic [NUM_SRC-1:0] clr_w;
   logic               any_w;
   logic [IW-1:0]      pick_w;
   logic [IW-1:0]      sel_w;
   logic [VEC_W-1:0]   fold_w;

   irq_pend_bank #(.NUM_SRC(NUM_SRC)) pend_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (src_pulse_i),
      .clr_i  (clr_w),
      .pend_o (pend_w)
   );

   irq_lowest_pick #(.NUM_SRC(NUM_SRC)) pick_i (
      .req_i (pend_w),
      .any_o (any_w),
      .idx_o (pick_w)
   );

   irq_vec_fold #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .GRANT_W(GRANT_W)) fold_i (
      .idx_i  (pick_w),
      .code_i (grant_code_i),
      .msi_i  (msi_en_i),
      .vec_o  (fold_w)
   );

   irq_hs_ctrl #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) ctrl_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .any_i   (any_w),
      .idx_i   (pick_w),
      .vec_i   (fold_w),
      .msi_i   (msi_en_i),
      .rdy_n_i (ep_rdy_n_i),
      .req_n_o (ep_req_n_o),
      .vec_o   (ep_vec_o),
      .leg_o   (legacy_o),
      .sel_o   (sel_w),
      .clr_o   (clr_w)
   );

   assert_vec_in_range_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ep_req_n_o) && !legacy_o) |->
         ((int'(ep_vec_o) >> grant_log_f(int'($past(grant_code_i)), IW)) == 0));

   assert_lowest_first_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ep_req_n_o) |->
         ((($past(pend_w) & ((NUM_SRC'(1) << sel_w) - NUM_SRC'(1))) == '0) &&
          (($past(pend_w) & (NUM_SRC'(1) << sel_w)) != '0)));

endmodule

// File: tb/msi_irq_req_tb_top.sv
`timescale 1ns/1ps
module msi_irq_req_tb_top;

   localparam int NS = 32;
   localparam int VW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] src = '0;
   logic          msi = 1'b1;
   logic [2:0]    code = 3'd5;
   logic          rdy_n = 1'b1;
   logic          req_n;
   logic [VW-1:0] vec;
   logic          leg;

   int total = 0;
   int fails = 0;

   always #2 clk = ~clk;

   msi_irq_req #(.NUM_SRC(NS), .VEC_W(VW), .GRANT_W(3)) dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .src_pulse_i  (src),
      .msi_en_i     (msi),
      .grant_code_i (code),
      .ep_rdy_n_i   (rdy_n),
      .ep_req_n_o   (req_n),
      .ep_vec_o     (vec),
      .legacy_o     (leg)
   );

   // {source, grant code, msi enable, expected vector, expected legacy}
   localparam int TBL [12][5] = '{
      '{ 0, 0, 1,  0, 0}, '{31, 0, 1,  0, 0}, '{ 5, 1, 1,  1, 0},
      '{ 6, 1, 1,  0, 0}, '{ 7, 2, 1,  3, 0}, '{13, 3, 1,  5, 0},
      '{29, 4, 1, 13, 0}, '{31, 5, 1, 31, 0}, '{22, 6, 1, 22, 0},
      '{17, 7, 1, 17, 0}, '{19, 5, 0,  0, 1}, '{ 3, 2, 0,  0, 1}
   };

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic pulse(input int idx);
      @(negedge clk) src = NS'(1) << idx;
      @(negedge clk) src = '0;
   endtask

   task automatic accept();
      @(negedge clk) rdy_n = 1'b0;
      @(negedge clk) rdy_n = 1'b1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 req_n", int'(req_n), 1);
      chk("R1 vec", int'(vec), 0);
      chk("R1 legacy", int'(leg), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R6: ready ignored while idle
      rdy_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R6 idle ready ignored", int'(req_n), 1);
      rdy_n = 1'b1;

      // R2 R4 R5 R10 table walk
      for (int t = 0; t < 12; t++) begin
         code = 3'(TBL[t][1]);
         msi  = TBL[t][2][0];
         pulse(TBL[t][0]);
         chk("R2 not yet raised", int'(req_n), 1);
         @(negedge clk);
         chk("R2 raised", int'(req_n), 0);
         chk("R4 R5 R10 vector", int'(vec), TBL[t][3]);
         chk("R4 R10 legacy", int'(leg), TBL[t][4]);
         accept();
         chk("R7 released", int'(req_n), 1);
      end
      msi  = 1'b1;
      code = 3'd5;

      // R3: lowest first, latched, stable while waiting
      @(negedge clk) src = (NS'(1) << 9) | (NS'(1) << 4);
      @(negedge clk) src = '0;
      @(negedge clk);
      chk("R3 lowest first", int'(vec), 4);
      pulse(2);
      chk("R3 latched", int'(vec), 4);
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         chk("R6 req held", int'(req_n), 0);
         chk("R6 vec held", int'(vec), 4);
      end
      accept();
      @(negedge clk);
      chk("R3 next lowest", int'(vec), 2);
      accept();
      @(negedge clk);
      chk("R3 last", int'(vec), 9);
      accept();

      // R8: merge repeated pulses
      pulse(1);
      @(negedge clk);
      chk("R8 first", int'(vec), 1);
      pulse(3);
      pulse(3);
      pulse(3);
      accept();
      @(negedge clk);
      chk("R8 merged raised", int'(req_n), 0);
      chk("R8 merged vec", int'(vec), 3);
      accept();
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         chk("R8 single request", int'(req_n), 1);
      end

      // R9: pulse during own acceptance
      pulse(6);
      @(negedge clk);
      chk("R9 raised", int'(vec), 6);
      @(negedge clk) begin rdy_n = 1'b0; src = NS'(1) << 6; end
      @(negedge clk) begin rdy_n = 1'b1; src = '0; end
      chk("R9 gap", int'(req_n), 1);
      @(negedge clk);
      chk("R9 again raised", int'(req_n), 0);
      chk("R9 again vec", int'(vec), 6);
      accept();

      // R11: enable drops mid-handshake
      pulse(10);
      @(negedge clk);
      chk("R11 msi vec", int'(vec), 10);
      msi = 1'b0;
      repeat (2) @(negedge clk);
      chk("R11 still pending", int'(req_n), 0);
      chk("R11 vec kept", int'(vec), 10);
      chk("R11 mode kept", int'(leg), 0);
      accept();
      pulse(10);
      @(negedge clk);
      chk("R11 now legacy", int'(leg), 1);
      chk("R11 legacy vec", int'(vec), 0);
      accept();

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule